// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one logic cell of a RAM-table-based gate array. It holds a 128-word by 2-bit lookup memory with seven address lines and two data outputs, plus two D registers that share one clock and one reset. The cell works in one of two table modes. In split mode the table gives two separate functions of five variables: one half of the address space drives output channel 0 and the other half drives channel 1. In feedback mode the two register outputs become the two upper address bits, so the table can act as the next-state logic of a small state machine.

Each register loads one of four values: table value 0, table value 1, its own current value (hold), or a direct serial data input. Chaining a register output into the direct input of the next cell builds a shift register that moves one bit per clock. Each output pin shows either its channel's table value or its channel's register. The table is written through a parallel write port while the configuration enable is high. Table reads are combinational.

Top module: `lut_cell`

## Requirements
- R1: When `cfg_en` and `wr_en` are both high at a rising clock edge, word `wr_addr` takes `wr_data`. The new value can be read combinationally right after that edge.
- R2: When `cfg_en` is low, a write request has no effect, and the addressed word keeps its old value.
- R3: When `fb_mode`=0, channel 0's table value is bit 0 of word {`page`,0,`in_var`} and channel 1's table value is bit 1 of word {`page`,1,`in_var`}. The address is written most significant bit first.
- R4: When `fb_mode`=1, both channels read the word {q1,q0,`in_var`}. Channel 0 takes bit 0 of that word and channel 1 takes bit 1.
- R5: At each rising edge, register c loads the value picked by its select. The encodings are 0 = table value 0, 1 = table value 1, 2 = hold its own value, 3 = `din`. `dsel_a` drives register 0 and `dsel_b` drives register 1.
- R6: `dout[c]` shows register c when `osel[c]`=1 and table value c when `osel[c]`=0. Both paths are combinational.
- R7: The reset `rst_n` is active low and asynchronous. It clears both registers to 0 without waiting for a clock edge.
- R8: Reset does not change the table contents.
- R9: When each cell uses `dsel_a`=3 and `osel[0]`=1, and each cell's `dout[0]` feeds the next cell's `din`, a chain of N cells is a shift register. The last stage shows a bit N rising edges after that bit was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and table writes |
| rst_n | input | 1 | Asynchronous active-low register reset |
| cfg_en | input | 1 | Configuration state; table writes are allowed only while high |
| wr_en | input | 1 | Table write request |
| wr_addr | input | IN_W+2 | Table word address for writes |
| wr_data | input | 2 | Word written to the table |
| fb_mode | input | 1 | 0 = split five-input mode, 1 = register feedback mode |
| page | input | 1 | Top address bit in split mode |
| in_var | input | IN_W | Logic input variables |
| din | input | 1 | Direct serial data input |
| dsel_a | input | 2 | Data source select for register 0 |
| dsel_b | input | 2 | Data source select for register 1 |
| osel | input | 2 | Per-channel output select: 0 = table, 1 = register |
| dout | output | 2 | Cell outputs |

## Verification
Table reads and output selection are combinational, so their results are due in the same cycle as the stimulus. The bench drives inputs 1 ns after a rising edge and samples 1 ns later, well before the next edge. Table writes and register loads are due one rising edge after the stimulus, so those values are sampled 1 ns after that edge. The asynchronous reset is checked between edges, with no clock edge in between. A bit sent into a chain of four cells is checked at the last stage four edges after it was driven.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

    // Number of table output channels / registers per cell
    localparam int unsigned NCH = 2;

    // Register data source select encoding
    typedef enum logic [1:0] {
        DSEL_F0   = 2'd0,
        DSEL_F1   = 2'd1,
        DSEL_HOLD = 2'd2,
        DSEL_DIN  = 2'd3
    } dsel_e;

endpackage

// File: rtl/lut_cell_addr.sv
module lut_cell_addr
    import lut_cell_pkg::*;
#(
    parameter int unsigned IN_W = 5,
    localparam int unsigned AW  = IN_W + 2
) (
    input  logic                    fb_mode,
    input  logic                    page,
    input  logic [IN_W-1:0]         in_var,
    input  logic [NCH-1:0]          q,
    output logic [NCH-1:0][AW-1:0]  raddr
);

    // One read address per channel: split mode keeps the channels in
    // separate halves, feedback mode puts both registers on top.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic HALF = (c != 0);
        always_comb begin
            if (fb_mode) begin
                raddr[c] = {q[1], q[0], in_var};
            end else begin
                raddr[c] = {page, HALF, in_var};
            end
        end
    end

endmodule

// File: rtl/lut_cell_dmux.sv
module lut_cell_dmux
    import lut_cell_pkg::*;
(
    input  logic [1:0]     sel,
    input  logic [NCH-1:0] f,
    input  logic           q_self,
    input  logic           din,
    output logic           d
);

    always_comb begin
        d = q_self;
        case (dsel_e'(sel))
            DSEL_F0:   d = f[0];
            DSEL_F1:   d = f[1];
            DSEL_HOLD: d = q_self;
            DSEL_DIN:  d = din;
        endcase
    end

endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
#(
    parameter int unsigned IN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              wr_en,
    input  logic [IN_W+1:0]   wr_addr,
    input  logic [1:0]        wr_data,
    input  logic              fb_mode,
    input  logic              page,
    input  logic [IN_W-1:0]   in_var,
    input  logic              din,
    input  logic [1:0]        dsel_a,
    input  logic [1:0]        dsel_b,
    input  logic [1:0]        osel,
    output logic [1:0]        dout
);

    localparam int unsigned AW    = IN_W + 2;
    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0][NCH-1:0] mem;
    } tbl_t;

    typedef struct packed {
        logic [NCH-1:0] q;
    } ff_t;

    tbl_t tbl_d, tbl_q;
    ff_t  ff_d,  ff_q;

    logic [NCH-1:0][AW-1:0] raddr;
    logic [NCH-1:0][1:0]    dsel_v;
    logic [NCH-1:0]         f;
    logic [NCH-1:0]         dnext;

    assign dsel_v = {dsel_b, dsel_a};

    lut_cell_addr #(.IN_W(IN_W)) u_addr (
        .fb_mode (fb_mode),
        .page    (page),
        .in_var  (in_var),
        .q       (ff_q.q),
        .raddr   (raddr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Combinational table read, one bit per channel
        assign f[c] = tbl_q.mem[raddr[c]][c];

        lut_cell_dmux u_dmux (
            .sel    (dsel_v[c]),
            .f      (f),
            .q_self (ff_q.q[c]),
            .din    (din),
            .d      (dnext[c])
        );

        assign dout[c] = osel[c] ? ff_q.q[c] : f[c];
    end

    // Next-state computation
    always_comb begin
        tbl_d = tbl_q;
        if (cfg_en && wr_en) begin
            tbl_d.mem[wr_addr] = wr_data;
        end
        ff_d.q = dnext;
    end

    // Table storage: configuration survives reset
    always_ff @(posedge clk) begin
        tbl_q <= tbl_d;
    end

    // Cell registers with asynchronous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_q <= '0;
        end else begin
            ff_q <= ff_d;
        end
    end

endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
    parameter int unsigned DEPTH = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_en,
    input logic               din,
    input logic [1:0]         dsel_a,
    input logic [1:0]         osel,
    input logic [1:0]         dout,
    input logic [1:0]         q,
    input logic [2*DEPTH-1:0] mem
);

    // R2: no table change outside the configuration state
    p_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (mem == $past(mem)));

    // R5: hold select keeps register 0
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel_a == 2'd2) |=> (q[0] == $past(q[0])));

    // R5: direct select loads din into register 0
    p_din_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel_a == 2'd3) |=> (q[0] == $past(din)));

    // R6: register path visible on the output
    p_oreg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        osel[1] |-> (dout[1] == q[1]));

    // R7: registers are clear whenever reset is held
    p_reset_r7: assert property (@(posedge clk)
        !rst_n |-> (q == 2'b00));

endmodule

bind lut_cell lut_cell_chk #(.DEPTH(DEPTH)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_en (cfg_en),
    .din    (din),
    .dsel_a (dsel_a),
    .osel   (osel),
    .dout   (dout),
    .q      (ff_q.q),
    .mem    (tbl_q.mem)
);

// File: tb/test_lut_cell.sv
`timescale 1ns/1ps
module test_lut_cell;

    localparam int NCHAIN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [1:0] wr_data = '0;
    logic       fb_mode = 1'b0, page = 1'b0;
    logic [4:0] in_var = '0;
    logic       din = 1'b0;
    logic [1:0] dsel_a = 2'd2, dsel_b = 2'd2;
    logic [1:0] osel = 2'b11;
    logic [1:0] dout;

    logic       sdin = 1'b0;
    logic [1:0] cdout [NCHAIN];

    int checks = 0;
    int fails  = 0;
    logic [1:0] shadow [128];

    always #2.5 clk = ~clk;

    lut_cell i_lut_cell (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .fb_mode(fb_mode),
        .page(page), .in_var(in_var), .din(din), .dsel_a(dsel_a),
        .dsel_b(dsel_b), .osel(osel), .dout(dout)
    );

    for (genvar k = 0; k < NCHAIN; k++) begin : g_chain
        logic cin;
        if (k == 0) begin : g_first
            assign cin = sdin;
        end else begin : g_next
            assign cin = cdout[k-1][0];
        end
        lut_cell i_stage (
            .clk(clk), .rst_n(rst_n), .cfg_en(1'b0), .wr_en(1'b0),
            .wr_addr(7'd0), .wr_data(2'd0), .fb_mode(1'b0),
            .page(1'b0), .in_var(5'd0), .din(cin), .dsel_a(2'd3),
            .dsel_b(2'd2), .osel(2'b01), .dout(cdout[k])
        );
    end

    // Stimulus for split-mode reads: {page, in_var}
    localparam logic [5:0] VEC [8] = '{
        6'b0_00000, 6'b0_00111, 6'b0_10101, 6'b0_11111,
        6'b1_00000, 6'b1_01100, 6'b1_10011, 6'b1_11110
    };

    function automatic logic [1:0] pat(int a);
        logic [6:0] x;
        x = a[6:0];
        return {logic'((a % 3) == 0), x[0] ^ x[3] ^ (x[6] & x[2])};
    endfunction

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [6:0] a, logic [1:0] d, logic en_cfg);
        cfg_en  = en_cfg;
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        if (en_cfg) shadow[a] = d;
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [1:0] e;
        logic [1:0] hist [10];
        #1;
        // R7: reset state
        chk("R7 reset state", dout, 2'b00);
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // Load the table (R1)
        for (int a = 0; a < 128; a++) wr(a[6:0], pat(a), 1'b1);
        cfg_en = 1'b0;

        // R3: split-mode vectors
        osel = 2'b00;
        fb_mode = 1'b0;
        for (int i = 0; i < 8; i++) begin
            page = VEC[i][5];
            in_var = VEC[i][4:0];
            #1;
            e = {shadow[{page, 1'b1, in_var}][1], shadow[{page, 1'b0, in_var}][0]};
            chk("R3 split read", dout, e);
            tick();
        end

        // R1: configured writes are visible right away
        wr({1'b0, 1'b0, 5'd9}, ~shadow[{1'b0, 1'b0, 5'd9}], 1'b1);
        wr({1'b0, 1'b1, 5'd9}, ~shadow[{1'b0, 1'b1, 5'd9}], 1'b1);
        cfg_en = 1'b0;
        page = 1'b0; in_var = 5'd9;
        #1;
        chk("R1 write readback",
            dout, {shadow[{1'b0, 1'b1, 5'd9}][1], shadow[{1'b0, 1'b0, 5'd9}][0]});
        tick();

        // R2: write without configuration state is ignored
        wr({1'b1, 1'b0, 5'd17}, ~shadow[{1'b1, 1'b0, 5'd17}], 1'b0);
        wr({1'b1, 1'b1, 5'd17}, ~shadow[{1'b1, 1'b1, 5'd17}], 1'b0);
        page = 1'b1; in_var = 5'd17;
        #1;
        chk("R2 ignored write",
            dout, {shadow[{1'b1, 1'b1, 5'd17}][1], shadow[{1'b1, 1'b0, 5'd17}][0]});
        tick();

        // R5: direct input, hold, table sources
        osel = 2'b11;
        dsel_a = 2'd3; dsel_b = 2'd3; din = 1'b1;
        tick();
        chk("R5 load din", dout, 2'b11);
        dsel_a = 2'd2; dsel_b = 2'd2; din = 1'b0;
        tick();
        chk("R5 hold", dout, 2'b11);
        page = 1'b0; in_var = 5'd9;
        dsel_a = 2'd0; dsel_b = 2'd1;
        e = {shadow[{1'b0, 1'b1, 5'd9}][1], shadow[{1'b0, 1'b0, 5'd9}][0]};
        tick();
        chk("R5 load table", dout, e);
        dsel_a = 2'd2; dsel_b = 2'd2;

        // R6: mixed output select
        osel = 2'b01;
        #1;
        chk("R6 osel mix", dout, {shadow[{1'b0, 1'b1, 5'd9}][1], e[0]});
        tick();

        // R4: feedback mode with q = 11 and q = 00
        dsel_a = 2'd3; dsel_b = 2'd3; din = 1'b1;
        tick();
        dsel_a = 2'd2; dsel_b = 2'd2;
        fb_mode = 1'b1; osel = 2'b00; in_var = 5'd9;
        #1;
        chk("R4 feedback q=11", dout, shadow[{2'b11, 5'd9}]);
        dsel_a = 2'd3; dsel_b = 2'd3; din = 1'b0;
        in_var = 5'd22;
        tick();
        dsel_a = 2'd2; dsel_b = 2'd2;
        #1;
        chk("R4 feedback q=00", dout, shadow[{2'b00, 5'd22}]);
        fb_mode = 1'b0;
        tick();

        // R7: asynchronous clear between edges
        dsel_a = 2'd3; dsel_b = 2'd3; din = 1'b1; osel = 2'b11;
        tick();
        chk("R7 preload", dout, 2'b11);
        dsel_a = 2'd2; dsel_b = 2'd2;
        rst_n = 1'b0;
        #1;
        chk("R7 async clear", dout, 2'b00);
        tick();
        rst_n = 1'b1;
        tick();

        // R8: table survives reset
        osel = 2'b00; page = 1'b0; in_var = 5'd9;
        #1;
        chk("R8 table kept",
            dout, {shadow[{1'b0, 1'b1, 5'd9}][1], shadow[{1'b0, 1'b0, 5'd9}][0]});
        tick();

        // R9: shift chain of NCHAIN cells
        for (int j = 0; j < 10; j++) begin
            hist[j] = {1'b0, logic'((j * 5 + 1) % 3 == 0) ^ logic'(j[0])};
            sdin = hist[j][0];
            tick();
            if (j >= NCHAIN - 1)
                chk("R9 shift chain", {1'b0, cdout[NCHAIN-1][0]}, hist[j-NCHAIN+1]);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule